// File: doc/BRIEF.md
# Host Address Decoder with Remappable Memory Window

This block sits behind the host bus interface of an expansion card and decides, for every host cycle, what the card does with it. It classifies the 24-bit host byte address into a region. It raises a claim flag when the card must answer the cycle. It raises a snoop flag when a host write to motherboard memory should also be copied into card memory, with the motherboard still acknowledging the cycle. It also produces the 25-bit address into the 32 MB card memory that the access maps to.

One 5-bit register selects which 1 MB-aligned slice of card memory appears through a 1 MB host window. The host reads and writes this register on the low byte lane of a fixed word address. A gap above host main memory is left unclaimed so that host memory sizing does not find extra RAM there. The decode is combinational from the cycle inputs. Only the window register is clocked.

Top module: `host_addr_decoder`

## Requirements
- R1: After synchronous reset the window offset is 0, so a read of the window register returns 0.
- R2: A valid write to $000008..$3FFFFF asserts snoop_wr, keeps claim low and drives mem_addr equal to the host address. A read there, or any access to $000000..$000007, asserts neither flag.
- R3: Any valid access to $400000..$4FFFFF asserts neither claim nor snoop_wr.
- R4: A valid access to $500000..$CFFFFF asserts claim and drives mem_addr = address − $100000, which lands in $400000..$BFFFFF.
- R5: A valid access to $D00000..$DFFFFF asserts claim and drives mem_addr = {window offset, address[19:0]}.
- R6: The window register occupies the word at $F00200/$F00201, matched on address bits 23..1. Any valid access to it asserts claim. A write with lds_n low loads wdata[4:0] into the offset at the next clock edge.
- R7: A write to the register word with lds_n high leaves the offset unchanged.
- R8: A valid read of the register word drives rdata = {11'b0, offset}. Otherwise rdata is 0.
- R9: Addresses $E00000..$FFFFFF, except the register word, are neither claimed nor snooped.
- R10: With cyc_valid low, claim and snoop_wr are low, rdata is 0, and the register does not change.
- R11: claim and snoop_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A host cycle is presented this clock |
| addr | input | 24 | Host byte address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| wdata | input | 16 | Host write data |
| claim | output | 1 | The card answers this cycle |
| snoop_wr | output | 1 | Copy this write into card memory without answering |
| mem_addr | output | 25 | Card memory byte address |
| rdata | output | 16 | Register read data |

## Verification
On every cycle the assertions check four things: claim and snoop are exclusive; the gap and idle cycles stay silent; snoops happen only on writes; and the window offset changes only through a low-lane register write. Address arithmetic is also asserted on every cycle: the window keeps the low 20 address bits and the expansion region's fixed displacement. Only the bench scenarios show that the region edges sit on exactly the right bytes. They also show that the window follows each of the 32 offsets after it is rewritten, and that the register value comes back on the read data.

// File: rtl/hdec_pkg.sv
package hdec_pkg;
    localparam int HADDR_W = 24;
    localparam int MADDR_W = 25;
    localparam int WIN_W   = 5;
    localparam int DATA_W  = 16;
    localparam int WIN_LOW_W = 20;

    localparam logic [HADDR_W-1:0] MAIN_LO = 24'h000008;
    localparam logic [HADDR_W-1:0] MAIN_HI = 24'h3FFFFF;
    localparam logic [HADDR_W-1:0] GAP_HI  = 24'h4FFFFF;
    localparam logic [HADDR_W-1:0] EXP_HI  = 24'hCFFFFF;
    localparam logic [HADDR_W-1:0] WIN_HI  = 24'hDFFFFF;
    localparam logic [HADDR_W-1:0] REG_ADR = 24'hF00200;
    localparam logic [MADDR_W-1:0] EXP_SHIFT = 25'h0100000;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_MAIN,
        RG_GAP,
        RG_EXP,
        RG_WIN,
        RG_REG
    } region_e;

    typedef struct packed {
        logic                claim;
        logic                snoop;
        logic [MADDR_W-1:0]  maddr;
    } xlate_t;

    function automatic region_e classify(input logic [HADDR_W-1:0] a);
        if (a[HADDR_W-1:1] == REG_ADR[HADDR_W-1:1]) return RG_REG;
        if (a < MAIN_LO)  return RG_NONE;
        if (a <= MAIN_HI) return RG_MAIN;
        if (a <= GAP_HI)  return RG_GAP;
        if (a <= EXP_HI)  return RG_EXP;
        if (a <= WIN_HI)  return RG_WIN;
        return RG_NONE;
    endfunction
endpackage

// File: rtl/hdec_region.sv
module hdec_region
    import hdec_pkg::*;
(
    input  logic [HADDR_W-1:0] addr,
    output region_e            region
);
    always_comb region = classify(addr);
endmodule

// File: rtl/hdec_xlate.sv
module hdec_xlate
    import hdec_pkg::*;
(
    input  logic               cyc_valid,
    input  logic               rd_nwr,
    input  region_e            region,
    input  logic [HADDR_W-1:0] addr,
    input  logic [WIN_W-1:0]   win,
    output xlate_t             xo
);
    localparam int PAD_W = MADDR_W - HADDR_W;

    always_comb begin
        xo = '0;
        unique case (region)
            RG_MAIN: begin
                xo.snoop = cyc_valid && !rd_nwr;
                xo.maddr = {{PAD_W{1'b0}}, addr};
            end
            RG_EXP: begin
                xo.claim = cyc_valid;
                xo.maddr = {{PAD_W{1'b0}}, addr} - EXP_SHIFT;
            end
            RG_WIN: begin
                xo.claim = cyc_valid;
                xo.maddr = {win, addr[WIN_LOW_W-1:0]};
            end
            RG_REG: begin
                xo.claim = cyc_valid;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hdec_winreg.sv
module hdec_winreg
    import hdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd_nwr,
    input  logic              lds_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [WIN_W-1:0]  win_q,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            win_q <= '0;
        else if (sel && !rd_nwr && !lds_n)
            win_q <= wdata[WIN_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (sel && rd_nwr)
            rdata[WIN_W-1:0] = win_q;
    end
endmodule

// File: rtl/host_addr_decoder.sv
module host_addr_decoder
    import hdec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cyc_valid,
    input  logic [HADDR_W-1:0] addr,
    input  logic               rd_nwr,
    input  logic               uds_n,
    input  logic               lds_n,
    input  logic [DATA_W-1:0]  wdata,
    output logic               claim,
    output logic               snoop_wr,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  rdata
);
    region_e          region;
    xlate_t           xo;
    logic [WIN_W-1:0] win_q;
    logic             reg_sel;
    logic             upper_unused;

    assign upper_unused = uds_n;

    hdec_region u_region (.addr(addr), .region(region));

    assign reg_sel = cyc_valid && (region == RG_REG);

    hdec_winreg u_win (
        .clk(clk), .rst(rst), .sel(reg_sel), .rd_nwr(rd_nwr),
        .lds_n(lds_n), .wdata(wdata), .win_q(win_q), .rdata(rdata)
    );

    hdec_xlate u_xlate (
        .cyc_valid(cyc_valid), .rd_nwr(rd_nwr), .region(region),
        .addr(addr), .win(win_q), .xo(xo)
    );

    assign claim    = xo.claim;
    assign snoop_wr = xo.snoop;
    assign mem_addr = xo.maddr;
endmodule

// File: rtl/hdec_checker.sv
module hdec_checker
    import hdec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cyc_valid,
    input logic [HADDR_W-1:0] addr,
    input logic               rd_nwr,
    input logic               lds_n,
    input logic               claim,
    input logic               snoop_wr,
    input logic [MADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]  rdata,
    input logic [WIN_W-1:0]   win_q
);
    logic reg_wr;
    logic in_gap, in_win, in_exp;
    assign reg_wr = cyc_valid && !rd_nwr && !lds_n && (addr[HADDR_W-1:1] == REG_ADR[HADDR_W-1:1]);
    assign in_gap = (addr > MAIN_HI) && (addr <= GAP_HI);
    assign in_exp = (addr > GAP_HI) && (addr <= EXP_HI);
    assign in_win = (addr > EXP_HI) && (addr <= WIN_HI);

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(claim && snoop_wr)); // R11
    AST_GAP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && in_gap) |-> (!claim && !snoop_wr)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> (!claim && !snoop_wr && rdata == '0)); // R10
    AST_SNOOP_WRITE: assert property (@(posedge clk) disable iff (rst)
        snoop_wr |-> (!rd_nwr && addr <= MAIN_HI && mem_addr[HADDR_W-1:0] == addr)); // R2
    AST_WIN_LOW: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && in_win) |-> (claim && mem_addr == {win_q, addr[WIN_LOW_W-1:0]})); // R5
    AST_EXP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && in_exp) |-> (claim && mem_addr + EXP_SHIFT == {1'b0, addr})); // R4
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(win_q)); // R7
endmodule

bind host_addr_decoder hdec_checker u_chk (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .addr(addr), .rd_nwr(rd_nwr),
    .lds_n(lds_n), .claim(claim), .snoop_wr(snoop_wr), .mem_addr(mem_addr),
    .rdata(rdata), .win_q(win_q)
);

// File: tb/sim_host_addr_decoder.sv
module sim_host_addr_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_valid = 1'b0;
    logic [23:0] addr = '0;
    logic        rd_nwr = 1'b1;
    logic        uds_n = 1'b1;
    logic        lds_n = 1'b1;
    logic [15:0] wdata = '0;
    logic        claim, snoop_wr;
    logic [24:0] mem_addr;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    int model_win = 0;
    bit done = 0;

    always #4 clk = ~clk;

    host_addr_decoder u0 (
        .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .addr(addr), .rd_nwr(rd_nwr),
        .uds_n(uds_n), .lds_n(lds_n), .wdata(wdata), .claim(claim),
        .snoop_wr(snoop_wr), .mem_addr(mem_addr), .rdata(rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, addr);
        end
    endtask

    // Present one cycle at the falling edge, sample shortly after.
    task automatic probe(input logic [23:0] a, input logic rd);
        int ia;
        bit ex_claim, ex_snoop, ex_map;
        int ex_ma;
        @(negedge clk);
        addr = a; rd_nwr = rd; cyc_valid = 1'b1; lds_n = 1'b0; uds_n = 1'b0;
        rd = rd; 
        #1;
        ia = int'(a);
        ex_claim = 0; ex_snoop = 0; ex_map = 0; ex_ma = 0;
        if (ia >= 'h8 && ia <= 'h3FFFFF) begin
            ex_snoop = !rd; ex_ma = ia; ex_map = !rd;
            chk("R2", {30'b0, claim, snoop_wr}, {30'b0, ex_claim, ex_snoop});
        end else if (ia >= 'h400000 && ia <= 'h4FFFFF) begin
            chk("R3", {30'b0, claim, snoop_wr}, 32'd0);
        end else if (ia >= 'h500000 && ia <= 'hCFFFFF) begin
            ex_claim = 1; ex_ma = ia - 'h100000; ex_map = 1;
            chk("R4", {30'b0, claim, snoop_wr}, 32'd2);
        end else if (ia >= 'hD00000 && ia <= 'hDFFFFF) begin
            ex_claim = 1; ex_ma = model_win * 'h100000 + (ia % 'h100000); ex_map = 1;
            chk("R5", {30'b0, claim, snoop_wr}, 32'd2);
        end else if (ia == 'hF00200 || ia == 'hF00201) begin
            chk("R6", {30'b0, claim, snoop_wr}, 32'd2);
        end else begin
            chk("R9", {30'b0, claim, snoop_wr}, 32'd0);
        end
        if (ex_map) chk(ia < 'h400000 ? "R2" : (ia < 'hD00000 ? "R4" : "R5"),
                        {7'b0, mem_addr}, ex_ma);
        chk("R11", {31'b0, claim && snoop_wr}, 32'd0);
        @(negedge clk);
        cyc_valid = 1'b0; lds_n = 1'b1; uds_n = 1'b1;
        #1;
        chk("R10", {15'b0, claim, snoop_wr, rdata[14:0]}, 32'd0);
    endtask

    task automatic reg_write(input logic [15:0] d, input logic low_lane, input logic valid);
        @(negedge clk);
        addr = 24'hF00201; rd_nwr = 1'b0; cyc_valid = valid;
        lds_n = !low_lane; uds_n = 1'b0; wdata = d;
        @(negedge clk);
        cyc_valid = 1'b0; lds_n = 1'b1; uds_n = 1'b1; rd_nwr = 1'b1;
        if (valid && low_lane) model_win = int'(d[4:0]);
    endtask

    task automatic reg_read(input string req);
        @(negedge clk);
        addr = 24'hF00200; rd_nwr = 1'b1; cyc_valid = 1'b1; lds_n = 1'b0;
        #1;
        chk(req, {16'b0, rdata}, model_win);
        @(negedge clk);
        cyc_valid = 1'b0; lds_n = 1'b1;
    endtask

    task automatic sweep();
        logic [23:0] edges [18] = '{24'h000000, 24'h000007, 24'h000008, 24'h123456,
            24'h3FFFFF, 24'h400000, 24'h4FFFFF, 24'h500000, 24'hCFFFFF, 24'hD00000,
            24'hD7ABCD, 24'hDFFFFF, 24'hE00000, 24'hEFFFFF, 24'hF00000, 24'hF001FF,
            24'hF00202, 24'hFFFFFF};
        foreach (edges[i]) begin
            probe(edges[i], 1'b1);
            probe(edges[i], 1'b0);
        end
        for (int k = 0; k < 256; k++) probe(24'(k * 'h10000 + 'h00A5), 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        reg_read("R1");
        sweep();
        // R8: reads elsewhere leave rdata zero
        probe(24'hD00000, 1'b1);
        chk("R8", {16'b0, rdata}, 32'd0);
        for (int w = 0; w < 32; w++) begin
            reg_write(16'hFFE0 | 16'(w), 1'b1, 1'b1);   // R6
            reg_read("R8");
            probe(24'hD00000, 1'b0);
            probe(24'hDFFFFF, 1'b1);
            probe(24'hDABCDE, 1'b1);
        end
        reg_write(16'h0003, 1'b0, 1'b1);               // R7: upper lane only
        reg_read("R7");
        reg_write(16'h0009, 1'b1, 1'b0);               // R10: not a valid cycle
        reg_read("R10");
        reg_write(16'h000C, 1'b1, 1'b1);
        reg_read("R6");
        sweep();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        model_win = 0;
        reg_read("R1");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule